// File: doc/BRIEF.md
# Rate-Selectable ADC Input FIFO

This block sits between a converter sample stream and a receive processing chain. Samples are written whenever they arrive, as marked by a valid strobe on the receive clock. A read strobe, derived from the same clock, drains the store at a programmable sub-rate: every cycle, every second, every fourth or every eighth cycle. When an external fractional resampler is active, the sub-rate is overridden. In its 1.5x decimation mode, the read strobe is further gated by the resampler's strobe.

One of several sync sources, chosen by a select input, re-initializes the write pointer, the read pointer and the read-rate counter. This gives a deterministic read phase. After a sync, reads start only once the store holds half its depth, which leaves room to absorb a small rate mismatch either way. Overflow and underflow raise sticky flags, and the next sync clears them. In bypass mode the store is skipped and each input sample is registered straight to the output.

Top module: `adc_rate_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it, `dout_valid`, `ovf_flag`, `udf_flag` and `dout` are all zero.
- R2: With bypass and the resampler off, a read opportunity occurs on cycles where the number of cycles since the last counter clear is a multiple of 2^`rate_sel`. Codes 0, 1, 2 and 3 give division by 1, 2, 4 and 8. The first opportunity is the first cycle after a sync.
- R3: After a sync, no sample is read until the store has held at least DEPTH/2 entries. Reads then return samples in write order. Each read yields a one-cycle `dout_valid` pulse in the cycle after the read opportunity, and `dout` holds its value between pulses.
- R4: With `resamp_en` high, `rate_sel` is ignored. When `resamp_dec15` is 0 (2x), every cycle is a read opportunity. When it is 1 (1.5x), only cycles with `resamp_gate` high are opportunities.
- R5: With `bypass` high, `dout_valid` follows `din_valid` one cycle later. `dout` takes `din` on cycles where `din_valid` is high. The store is neither written nor read, and the flags hold.
- R6: When `sync_src[sync_sel]` is high, the pointers, the occupancy, the priming state and the rate counter are reset, both flags clear, and `dout_valid` is low on the next cycle. A sample arriving in that cycle is discarded. Bits of `sync_src` that `sync_sel` does not select have no effect.
- R7: A write arriving while the store is full, and no read frees a slot in the same cycle, is dropped and sets `ovf_flag`. The flag stays set until a sync.
- R8: A read opportunity after priming that finds the store empty sets `udf_flag`. The flag stays set until a sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | DATA_W | Input sample |
| din_valid | input | 1 | Sample arrival strobe |
| rate_sel | input | 2 | Read sub-rate code (divide by 1/2/4/8) |
| bypass | input | 1 | Skip the store and register input directly |
| resamp_en | input | 1 | Resampler active, overrides rate_sel |
| resamp_dec15 | input | 1 | Resampler decimation: 1 = 1.5x, 0 = 2x |
| resamp_gate | input | 1 | Resampler read-gating strobe |
| sync_src | input | NSYNC | Candidate sync events |
| sync_sel | input | clog2(NSYNC) | Index of the sync source in use |
| dout | output | DATA_W | Output sample |
| dout_valid | output | 1 | Output sample strobe |
| ovf_flag | output | 1 | Sticky overflow indicator |
| udf_flag | output | 1 | Sticky underflow indicator |

## Verification
A corrupted pointer shows up within one read cycle as an out-of-order or repeated value on `dout`, because input samples are a running count. A wrong read-rate counter or priming state shifts the first `dout_valid` pulse after a sync, or its spacing, by at least one cycle. The bench compares every cycle against an arithmetic reference queue, so these errors appear at once. An occupancy error appears as a spurious or missing flag within a few reads of the store filling or draining.

// File: rtl/adc_rate_fifo_pkg.sv
// Shared definitions for the rate-selectable input FIFO.
// Assumes the rate code is two bits and the divider counter three bits.
package adc_rate_fifo_pkg;

    localparam int RATE_W = 2;
    localparam int DIV_W  = 3;

    typedef enum logic [RATE_W-1:0] {
        RATE_DIV1 = 2'd0,
        RATE_DIV2 = 2'd1,
        RATE_DIV4 = 2'd2,
        RATE_DIV8 = 2'd3
    } rate_e;

    // Low-bit mask of the divider counter that must be zero for a read strobe.
    function automatic logic [DIV_W-1:0] rate_mask(input logic [RATE_W-1:0] code);
        logic [DIV_W-1:0] m;
        m = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/adc_rate_gen.sv
// Read strobe generator: a free-running counter, cleared by sync, whose
// masked low bits give divide-by-1/2/4/8. Resampler mode overrides the rate
// and optionally gates the strobe. Assumes rate code 0..3.
module adc_rate_gen
    import adc_rate_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              resamp_en,
    input  logic              resamp_dec15,
    input  logic              resamp_gate,
    output logic              rd_stb
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;
    logic             gate_ok;

    // Divider counter: free running, re-phased by sync.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_cnt <= '0;
        else if (clear) div_cnt <= '0;
        else            div_cnt <= div_cnt + 1'b1;
    end

    // Strobe decode: resampler forces full rate and may gate it.
    always_comb begin
        mask    = resamp_en ? '0 : rate_mask(rate_sel);
        gate_ok = !resamp_en || !resamp_dec15 || resamp_gate;
        rd_stb  = ((div_cnt & mask) == '0) && gate_ok;
    end

endmodule

// File: rtl/adc_fifo_store.sv
// Sample store with write/read pointers, occupancy, priming and sticky flags.
// Reads begin once occupancy reaches DEPTH/2 after a clear. Assumes DEPTH
// is a power of two so pointers wrap naturally.
module adc_fifo_store #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              push_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf,
    output logic              udf
);

    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              primed;
    logic              empty, full, push, over_evt, under_evt;

    // Handshake decode for this cycle.
    always_comb begin
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        pop       = enable && !clear && primed && rd_stb && !empty;
        push      = enable && !clear && push_req && (!full || pop);
        over_evt  = enable && !clear && push_req && full && !pop;
        under_evt = enable && !clear && primed && rd_stb && empty;
        rd_data   = mem[rd_ptr];
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Pointer, occupancy, priming and flag state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            primed <= 1'b0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count  <= count + CW'(push) - CW'(pop);
            primed <= primed || (count >= CW'(HALF));
            ovf    <= ovf || over_evt;
            udf    <= udf || under_evt;
        end
    end

endmodule

// File: rtl/adc_rate_fifo.sv
// Top level: sync source selection, rate generator, store and output stage.
// Bypass registers input samples directly; otherwise the store is drained
// at the selected sub-rate. Assumes a single receive clock domain.
module adc_rate_fifo
    import adc_rate_fifo_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8,
    parameter int NSYNC  = 8,
    localparam int SEL_W = $clog2(NSYNC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic [1:0]        rate_sel,
    input  logic              bypass,
    input  logic              resamp_en,
    input  logic              resamp_dec15,
    input  logic              resamp_gate,
    input  logic [NSYNC-1:0]  sync_src,
    input  logic [SEL_W-1:0]  sync_sel,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              ovf_flag,
    output logic              udf_flag
);

    logic              sync_hit;
    logic              rd_stb;
    logic              pop;
    logic [DATA_W-1:0] rd_data;

    // Sync source multiplexer.
    always_comb sync_hit = sync_src[sync_sel];

    adc_rate_gen u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (sync_hit),
        .rate_sel     (rate_sel),
        .resamp_en    (resamp_en),
        .resamp_dec15 (resamp_dec15),
        .resamp_gate  (resamp_gate),
        .rd_stb       (rd_stb)
    );

    adc_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sync_hit),
        .enable   (!bypass),
        .push_req (din_valid),
        .wr_data  (din),
        .rd_stb   (rd_stb),
        .pop      (pop),
        .rd_data  (rd_data),
        .ovf      (ovf_flag),
        .udf      (udf_flag)
    );

    // Output register: bypass path or store read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else if (sync_hit) begin
            dout_valid <= 1'b0;
        end else if (bypass) begin
            dout_valid <= din_valid;
            if (din_valid) dout <= din;
        end else begin
            dout_valid <= pop;
            if (pop) dout <= rd_data;
        end
    end

endmodule

// File: rtl/adc_rate_fifo_chk.sv
// Port-level property checker for adc_rate_fifo, attached by bind.
// Assumes synchronous active-low reset held for at least one edge.
module adc_rate_fifo_chk #(
    parameter int DATA_W = 12,
    parameter int NSYNC  = 8,
    localparam int SEL_W = $clog2(NSYNC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic              din_valid,
    input logic              bypass,
    input logic              resamp_en,
    input logic              resamp_dec15,
    input logic              resamp_gate,
    input logic [NSYNC-1:0]  sync_src,
    input logic [SEL_W-1:0]  sync_sel,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              ovf_flag,
    input logic              udf_flag
);

    logic hit;
    always_comb hit = sync_src[sync_sel];

    AST_SYNC_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n) hit |=> !dout_valid); // R6
    AST_SYNC_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) hit |=> (!ovf_flag && !udf_flag)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag && !hit) |=> ovf_flag); // R7
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (udf_flag && !hit) |=> udf_flag); // R8
    AST_BYPASS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (bypass && !hit) |=> (dout_valid == $past(din_valid))); // R5
    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (bypass && din_valid && !hit) |=> (dout == $past(din))); // R5
    AST_RESAMP_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!bypass && resamp_en && resamp_dec15 && !resamp_gate && !hit) |=> !dout_valid); // R4

endmodule

bind adc_rate_fifo adc_rate_fifo_chk #(
    .DATA_W (DATA_W),
    .NSYNC  (NSYNC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .din          (din),
    .din_valid    (din_valid),
    .bypass       (bypass),
    .resamp_en    (resamp_en),
    .resamp_dec15 (resamp_dec15),
    .resamp_gate  (resamp_gate),
    .sync_src     (sync_src),
    .sync_sel     (sync_sel),
    .dout         (dout),
    .dout_valid   (dout_valid),
    .ovf_flag     (ovf_flag),
    .udf_flag     (udf_flag)
);

// File: tb/adc_rate_fifo_bench.sv
// Self-checking bench: a reference queue model, computed from the
// requirements, is compared with the outputs every cycle.
module adc_rate_fifo_bench;

    localparam int DW    = 12;
    localparam int DEPTH = 8;
    localparam int NS    = 8;
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic          din_valid = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic          bypass = 1'b0;
    logic          resamp_en = 1'b0;
    logic          resamp_dec15 = 1'b0;
    logic          resamp_gate = 1'b0;
    logic [NS-1:0] sync_src = '0;
    logic [2:0]    sync_sel = 3'd6;
    logic [DW-1:0] dout;
    logic          dout_valid, ovf_flag, udf_flag;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    adc_rate_fifo u_adc_rate_fifo (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .rate_sel(rate_sel), .bypass(bypass), .resamp_en(resamp_en),
        .resamp_dec15(resamp_dec15), .resamp_gate(resamp_gate),
        .sync_src(sync_src), .sync_sel(sync_sel), .dout(dout),
        .dout_valid(dout_valid), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    // Reference model state.
    int          q[$];
    int          m_cnt = 0;
    bit          m_primed = 0, m_ovf = 0, m_udf = 0, m_dv = 0;
    int          m_do = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_cnt = 0; m_primed = 0; m_ovf = 0; m_udf = 0; m_dv = 0; m_do = 0;
        end else if (sync_src[sync_sel]) begin
            q.delete(); m_cnt = 0; m_primed = 0; m_ovf = 0; m_udf = 0; m_dv = 0;
        end else begin
            automatic bit prim_next = m_primed || (q.size() >= HALF);
            if (bypass) begin
                m_dv = din_valid;
                if (din_valid) m_do = int'(din);
            end else begin
                automatic int  eff = resamp_en ? 0 : int'(rate_sel);
                automatic bit  stb = ((m_cnt % (1 << eff)) == 0) &&
                                     (!resamp_en || !resamp_dec15 || resamp_gate);
                automatic bit  popn = m_primed && stb && (q.size() > 0);
                if (m_primed && stb && q.size() == 0) m_udf = 1;
                m_dv = popn;
                if (popn) m_do = q.pop_front();
                if (din_valid) begin
                    if (q.size() < DEPTH) q.push_back(int'(din));
                    else m_ovf = 1;
                end
            end
            m_primed = prim_next;
            m_cnt = (m_cnt + 1) % 8;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dout_valid !== m_dv || (m_dv && int'(dout) !== m_do)) begin
                errors++;
                $display("FAIL %s: dout_valid=%0b dout=%0d expected dout_valid=%0b dout=%0d",
                         cur_req, dout_valid, dout, m_dv, m_do);
            end
            checks++;
            if (ovf_flag !== m_ovf || udf_flag !== m_udf) begin
                errors++;
                $display("FAIL %s: ovf=%0b udf=%0b expected ovf=%0b udf=%0b",
                         cur_req, ovf_flag, udf_flag, m_ovf, m_udf);
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // wp > 0: write every wp cycles; wp == 0: no writes; wp < 0: two of three.
    task automatic run(input int n, input int wp, input bit gpat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wp > 0)      din_valid = (i % wp) == 0;
            else if (wp < 0) din_valid = (i % 3) != 2;
            else             din_valid = 1'b0;
            if (din_valid) din = din + 1'b1;
            resamp_gate = gpat ? ((i % 3) != 2) : 1'b1;
        end
        @(negedge clk);
        din_valid = 1'b0;
    endtask

    task automatic do_sync(input int sel);
        @(negedge clk);
        sync_sel = 3'(sel);
        sync_src = NS'(1) << sel;
        din_valid = 1'b1;
        din = din + 1'b1;
        @(negedge clk);
        sync_src = '0;
        din_valid = 1'b0;
    endtask

    task automatic pulse_other;
        @(negedge clk);
        sync_src = NS'(1) << ((int'(sync_sel) + 1) % NS);
        @(negedge clk);
        sync_src = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_bit("R1", dout_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check_bit("R1", dout_valid, 1'b0);
        check_bit("R1", ovf_flag, 1'b0);
        check_bit("R1", udf_flag, 1'b0);
        check_bit("R1", dout == '0, 1'b1);

        // R2 and R3: matched write rate for every rate code, each sync source.
        for (int r = 0; r < 4; r++) begin
            cur_req = "R2";
            rate_sel = 2'(r);
            do_sync(r);
            cur_req = "R3";
            run(40 * (1 << r), 1 << r, 1'b0);
            check_bit("R2", ovf_flag | udf_flag, 1'b0);
        end

        // R6: unselected sources ignored, selected one re-phases.
        for (int s = 0; s < NS; s++) begin
            cur_req = "R6";
            rate_sel = 2'd1;
            do_sync(s);
            run(30, 2, 1'b0);
            pulse_other();
            run(20, 2, 1'b0);
        end

        // R7: writes faster than reads.
        cur_req = "R7";
        rate_sel = 2'd3;
        do_sync(6);
        run(60, 1, 1'b0);
        check_bit("R7", ovf_flag, 1'b1);
        run(10, 0, 1'b0);
        check_bit("R7", ovf_flag, 1'b1);
        do_sync(6);
        @(negedge clk);
        check_bit("R6", ovf_flag, 1'b0);

        // R8: reads faster than writes.
        cur_req = "R8";
        rate_sel = 2'd0;
        do_sync(6);
        run(60, 2, 1'b0);
        check_bit("R8", udf_flag, 1'b1);
        do_sync(6);
        @(negedge clk);
        check_bit("R6", udf_flag, 1'b0);

        // R4: resampler overrides the rate code; 2x then gated 1.5x.
        cur_req = "R4";
        rate_sel = 2'd3;
        resamp_en = 1'b1;
        resamp_dec15 = 1'b0;
        do_sync(6);
        run(120, 1, 1'b1);
        resamp_dec15 = 1'b1;
        do_sync(6);
        run(150, -1, 1'b1);
        check_bit("R4", ovf_flag | udf_flag, 1'b0);
        resamp_en = 1'b0;

        // R5: bypass path, flags held.
        cur_req = "R5";
        bypass = 1'b1;
        do_sync(6);
        run(50, 2, 1'b0);
        run(30, 1, 1'b0);
        bypass = 1'b0;
        do_sync(6);
        run(40, 1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule